// File: doc/BRIEF.md
# Lazy condition-code flag evaluator

This block produces the negative, zero, overflow and carry flags of a 32-bit processor after the fact. The arithmetic has already been done elsewhere. The pipeline records the operation class, the operand size, the source and destination operands and the result, plus the high word of a multiply. When the flags are finally needed, this block turns that record into flag values and merges them into the current status word.

Overflow and carry are derived only from the operand and result sign bits; no adder is present. For subtract and compare the source sign is inverted and the final carry is flipped. Multiplies are judged on the 64-bit value formed by the high word and the result. A carry-propagate move reports its carry in a separate flag. The merge writes only the bits an instruction is allowed to touch, always clears the extend flag, and under extended arithmetic lets the zero flag be cleared but never set.

The merged word is driven through one register stage, selected by a parameter. A two-flop synchronizer releases the register's asynchronous reset on a clock edge.

Top module: `ccflag_eval`

## Requirements
- R1: Status bit positions are C=0, V=1, Z=2, N=3, X=4, R=8. Class codes are ADD=0, SUB=1, CMP=2, MOVE=3 (also used for logic and shift), MULS=4, MULU=5, MCP=6, LIVE=7. For ADD with a negative result at the selected size, N is set. V is set when both operand sign bits are 0, and C is set when both operand sign bits are 1.
- R2: For ADD with a non-negative result, Z is set when the size-masked result is zero. V is set when both operand sign bits are 1, and C is set when either operand sign bit is 1.
- R3: Size codes 1, 2 and 4 select bit 7, 15 or 31 as the sign bit, and the low 8, 16 or 32 result bits for the zero test.
- R4: For SUB and CMP, the source is bitwise inverted before the R1/R2 tests, and the resulting C is inverted.
- R5: For MOVE, only N (the result sign) and Z (the size-masked result is zero) can be set. V and C are produced as 0.
- R6: MULS ignores the size code. N and Z come from the 64-bit value {hi, res}, and V is set when hi is not the sign extension of res bit 31.
- R7: MULU ignores the size code. N is bit 63 of {hi, res}, Z is set when that value is zero, and V is set whenever hi is nonzero.
- R8: MCP follows the ADD rules but places the carry result in R. C is produced as 0.
- R9: For every class except LIVE, bits outside the write mask keep their old value, except X. Every bit in the mask takes the new flag value, or 0 where no flag is produced. X always ends up 0.
- R10: When the xmode input is 1 and the new Z is 1, Z keeps its old value, so Z can be cleared but not set.
- R11: For a size code other than 1, 2 or 4, the classes ADD, SUB, CMP, MOVE and MCP produce no flags, but the masked writeback still takes place and X is still cleared.
- R12: LIVE passes the old status word through unchanged, including X.
- R13: With REG_OUT=1 (the default), the output shows the result one clock after the inputs are applied. The output is 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Recorded operation class |
| op_size | input | 3 | Operand size in bytes (1, 2, 4) |
| src | input | 32 | Recorded source operand |
| dst | input | 32 | Recorded destination operand |
| res | input | 32 | Recorded result |
| mul_hi | input | 32 | High word of a multiply |
| xmode | input | 1 | Extended-arithmetic mode |
| wr_mask | input | 32 | Bits the instruction may write |
| stat_in | input | 32 | Current status word |
| status_out | output | 32 | New status word |

## Verification
The bench targets the sign-only carry rules. A byte add whose low eight bits wrap to zero must raise Z, V and C together, and a design that tested all 32 bits would miss Z. Two equal operands under subtract must leave C clear, and a design that forgot either the source inversion or the final carry flip would report a borrow. On the multiply side, the bench uses a signed product whose result word is negative while the high word is zero. That case must give V without N, which catches both a 32-bit sign test and a wrong sign-extension compare. The bench also checks that extend mode never sets Z, that an unsupported size still clears X and the masked bits, that the carry-propagate move reports its carry in R rather than C, and that the pass-through class leaves X standing.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;
  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;
  localparam int FL_X = 4;
  localparam int FL_R = 8;

  typedef enum logic [2:0] {
    CC_ADD  = 3'd0,
    CC_SUB  = 3'd1,
    CC_CMP  = 3'd2,
    CC_MOVE = 3'd3,
    CC_MULS = 3'd4,
    CC_MULU = 3'd5,
    CC_MCP  = 3'd6,
    CC_LIVE = 3'd7
  } cc_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/ccflag_lanes.sv
module ccflag_lanes #(
  parameter int DW  = 32,
  parameter int SZW = 3
) (
  input  logic [SZW-1:0] size,
  input  logic [DW-1:0]  src,
  input  logic [DW-1:0]  dst,
  input  logic [DW-1:0]  res,
  output logic           s_sign,
  output logic           d_sign,
  output logic           r_sign,
  output logic           r_zero,
  output logic           size_ok
);
  localparam int NL = $clog2(DW / 8) + 1;

  logic [NL-1:0] hit, ls, ld, lr, lz;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int LW = 8 << i;
    assign hit[i] = (size == SZW'(1 << i));
    assign ls[i]  = src[LW-1];
    assign ld[i]  = dst[LW-1];
    assign lr[i]  = res[LW-1];
    assign lz[i]  = (res[LW-1:0] == '0);
  end

  always_comb begin
    s_sign  = 1'b0;
    d_sign  = 1'b0;
    r_sign  = 1'b0;
    r_zero  = 1'b0;
    for (int k = 0; k < NL; k++) begin
      s_sign = s_sign | (hit[k] & ls[k]);
      d_sign = d_sign | (hit[k] & ld[k]);
      r_sign = r_sign | (hit[k] & lr[k]);
      r_zero = r_zero | (hit[k] & lz[k]);
    end
    size_ok = |hit;
  end

  logic unused_bits;
  assign unused_bits = ^{src, dst};
endmodule

// File: rtl/ccflag_arith.sv
module ccflag_arith
  import ccflag_pkg::*;
(
  input  logic  s_sign,
  input  logic  d_sign,
  input  logic  r_sign,
  input  logic  r_zero,
  input  logic  is_sub,
  output nzvc_t fl
);
  logic s_eff;

  always_comb begin
    s_eff = is_sub ? ~s_sign : s_sign;
    fl    = '0;
    if (r_sign) begin
      fl.n = 1'b1;
      fl.v = ~s_eff & ~d_sign;
      fl.c = s_eff & d_sign;
    end else begin
      fl.z = r_zero;
      fl.v = s_eff & d_sign;
      fl.c = s_eff | d_sign;
    end
    if (is_sub) fl.c = ~fl.c;
  end
endmodule

// File: rtl/ccflag_mul.sv
module ccflag_mul
  import ccflag_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic          signed_mode,
  output nzvc_t         fl
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod = {hi, lo};
    fl   = '0;
    fl.z = (prod == '0);
    fl.n = prod[2*DW-1];
    if (signed_mode) begin
      fl.v = lo[DW-1] ? (hi != '1) : (hi != '0);
    end else begin
      fl.v = (hi != '0);
    end
  end
endmodule

// File: rtl/ccflag_merge.sv
module ccflag_merge
  import ccflag_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic [SW-1:0] flags,
  input  logic [SW-1:0] wr_mask,
  input  logic          xmode,
  input  logic [SW-1:0] stat_in,
  output logic [SW-1:0] stat_out
);
  logic [SW-1:0] eff;

  always_comb begin
    eff        = wr_mask;
    eff[FL_X]  = 1'b1;
    if (xmode) eff[FL_Z] = eff[FL_Z] & ~flags[FL_Z];
    stat_out   = (stat_in & ~eff) | (flags & eff);
  end
endmodule

// File: rtl/ccflag_eval.sv
module ccflag_eval
  import ccflag_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SW      = 32,
  parameter int SZW     = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     op_class,
  input  logic [SZW-1:0] op_size,
  input  logic [DW-1:0]  src,
  input  logic [DW-1:0]  dst,
  input  logic [DW-1:0]  res,
  input  logic [DW-1:0]  mul_hi,
  input  logic           xmode,
  input  logic [SW-1:0]  wr_mask,
  input  logic [SW-1:0]  stat_in,
  output logic [SW-1:0]  status_out
);
  cc_class_e     cls;
  logic          s_sign, d_sign, r_sign, r_zero, size_ok, is_sub, is_mul_s;
  nzvc_t         fl_ar, fl_mu;
  logic [SW-1:0] flags, merged, status_d;
  logic [1:0]    rst_sync;
  logic          core_rst_n;

  assign cls      = cc_class_e'(op_class);
  assign is_sub   = (cls == CC_SUB) || (cls == CC_CMP);
  assign is_mul_s = (cls == CC_MULS);

  ccflag_lanes #(.DW(DW), .SZW(SZW)) u_lanes (
    .size(op_size), .src(src), .dst(dst), .res(res),
    .s_sign(s_sign), .d_sign(d_sign), .r_sign(r_sign),
    .r_zero(r_zero), .size_ok(size_ok)
  );

  ccflag_arith u_arith (
    .s_sign(s_sign), .d_sign(d_sign), .r_sign(r_sign),
    .r_zero(r_zero), .is_sub(is_sub), .fl(fl_ar)
  );

  ccflag_mul #(.DW(DW)) u_mul (
    .hi(mul_hi), .lo(res), .signed_mode(is_mul_s), .fl(fl_mu)
  );

  always_comb begin
    flags = '0;
    unique case (cls)
      CC_ADD, CC_SUB, CC_CMP: begin
        if (size_ok) begin
          flags[FL_N] = fl_ar.n;
          flags[FL_Z] = fl_ar.z;
          flags[FL_V] = fl_ar.v;
          flags[FL_C] = fl_ar.c;
        end
      end
      CC_MOVE: begin
        if (size_ok) begin
          flags[FL_N] = r_sign;
          flags[FL_Z] = r_zero & ~r_sign;
        end
      end
      CC_MCP: begin
        if (size_ok) begin
          flags[FL_N] = fl_ar.n;
          flags[FL_Z] = fl_ar.z;
          flags[FL_V] = fl_ar.v;
          flags[FL_R] = fl_ar.c;
        end
      end
      CC_MULS, CC_MULU: begin
        flags[FL_N] = fl_mu.n;
        flags[FL_Z] = fl_mu.z;
        flags[FL_V] = fl_mu.v;
        flags[FL_C] = fl_mu.c;
      end
      default: flags = '0;
    endcase
  end

  ccflag_merge #(.SW(SW)) u_merge (
    .flags(flags), .wr_mask(wr_mask), .xmode(xmode),
    .stat_in(stat_in), .stat_out(merged)
  );

  assign status_d = (cls == CC_LIVE) ? stat_in : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  if (REG_OUT) begin : g_reg
    logic [SW-1:0] status_q;
    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) status_q <= '0;
      else             status_q <= status_d;
    end
    assign status_out = status_q;
  end else begin : g_comb
    assign status_out = status_d;
  end
endmodule

// File: rtl/ccflag_eval_chk.sv
module ccflag_eval_chk
  import ccflag_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic [2:0]    op_class,
  input logic          xmode,
  input logic [DW-1:0] mul_hi,
  input logic [SW-1:0] wr_mask,
  input logic [SW-1:0] stat_in,
  input logic [SW-1:0] status_out
);
  localparam logic [SW-1:0] XB = SW'(1) << FL_X;

  if (REG_OUT) begin : g_props
    // R9
    x_clear_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (op_class != CC_LIVE) |=> !status_out[FL_X]);

    // R9
    keep_unmasked_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (op_class != CC_LIVE) |=>
        (((status_out ^ $past(stat_in)) & ~($past(wr_mask) | XB)) == '0));

    // R12
    live_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (op_class == CC_LIVE) |=> (status_out == $past(stat_in)));

    // R10
    sticky_z_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (xmode && !stat_in[FL_Z] && op_class != CC_LIVE) |=> !status_out[FL_Z]);

    // R7
    mulu_ovf_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (op_class == CC_MULU && mul_hi != '0 && wr_mask[FL_V]) |=> status_out[FL_V]);

    // R5
    move_no_carry_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (op_class == CC_MOVE && !stat_in[FL_C] && !stat_in[FL_V]) |=>
        (!status_out[FL_C] && !status_out[FL_V]));
  end
endmodule

bind ccflag_eval ccflag_eval_chk #(.DW(DW), .SW(SW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .op_class(op_class), .xmode(xmode),
  .mul_hi(mul_hi), .wr_mask(wr_mask), .stat_in(stat_in), .status_out(status_out)
);

// File: tb/ccflag_eval_tb.sv
module ccflag_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_class, op_size;
  logic [31:0] src, dst, res, mul_hi, wr_mask, stat_in, status_out;
  logic        xmode;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  ccflag_eval u_dut (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_size(op_size),
    .src(src), .dst(dst), .res(res), .mul_hi(mul_hi), .xmode(xmode),
    .wr_mask(wr_mask), .stat_in(stat_in), .status_out(status_out)
  );

  task automatic check(input string req, input logic [31:0] exp);
    total++;
    if (status_out !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, status_out, exp);
    end
  endtask

  task automatic run(input logic [2:0] oc, input logic [2:0] sz,
                     input logic [31:0] s, input logic [31:0] d,
                     input logic [31:0] r, input logic [31:0] h,
                     input logic xm, input logic [31:0] m,
                     input logic [31:0] st);
    @(negedge clk);
    op_class = oc; op_size = sz; src = s; dst = d; res = r;
    mul_hi = h; xmode = xm; wr_mask = m; stat_in = st;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_class = 3'd7; op_size = 3'd4; src = '0; dst = '0; res = '0;
    mul_hi = '0; xmode = 1'b0; wr_mask = '1; stat_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R13 reset", 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_add;
    run(3'd0, 3'd4, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 32'hF, 0);
    check("R1 add neg overflow", 32'hA);
    run(3'd0, 3'd4, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 32'hF, 0);
    check("R2 add zero carry", 32'h5);
  endtask

  task automatic t_sizes;
    run(3'd0, 3'd1, 32'h80, 32'h80, 32'h100, 0, 0, 32'hF, 0);
    check("R3 byte wrap", 32'h7);
    run(3'd0, 3'd2, 32'h7FFF, 32'h1, 32'h8000, 0, 0, 32'hF, 0);
    check("R3 half neg", 32'hA);
  endtask

  task automatic t_sub;
    run(3'd1, 3'd4, 32'h1, 32'h1, 32'h0, 0, 0, 32'hF, 0);
    check("R4 sub equal", 32'h4);
    run(3'd1, 3'd4, 32'h1, 32'h0, 32'hFFFF_FFFF, 0, 0, 32'hF, 0);
    check("R4 sub borrow", 32'h9);
    run(3'd2, 3'd4, 32'h5, 32'h5, 32'h0, 0, 0, 32'hF, 0);
    check("R4 cmp equal", 32'h4);
  endtask

  task automatic t_move;
    run(3'd3, 3'd2, 32'hFFFF, 32'hFFFF, 32'h8000, 0, 0, 32'hF, 0);
    check("R5 move half neg", 32'h8);
    run(3'd3, 3'd2, 32'hFFFF, 32'hFFFF, 32'h1_0000, 0, 0, 32'hF, 0);
    check("R5 move half zero", 32'h4);
    run(3'd3, 3'd1, 0, 0, 32'h180, 0, 0, 32'hF, 0);
    check("R5 move byte neg", 32'h8);
  endtask

  task automatic t_mul;
    run(3'd4, 3'd0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'hF, 0);
    check("R6 muls minus one", 32'h8);
    run(3'd4, 3'd0, 0, 0, 32'h8000_0000, 32'h0, 0, 32'hF, 0);
    check("R6 muls bad extension", 32'h2);
    run(3'd5, 3'd0, 0, 0, 32'h0, 32'h8000_0000, 0, 32'hF, 0);
    check("R7 mulu high", 32'hA);
    run(3'd5, 3'd0, 0, 0, 32'h0, 32'h0, 0, 32'hF, 0);
    check("R7 mulu zero", 32'h4);
  endtask

  task automatic t_mcp;
    run(3'd6, 3'd4, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 32'h10F, 32'h1);
    check("R8 mcp carry in R", 32'h104);
  endtask

  task automatic t_mask;
    run(3'd0, 3'd4, 32'h1, 32'h1, 32'h2, 0, 0, 32'h3, 32'hFFFF_FFFF);
    check("R9 mask keep", 32'hFFFF_FFEC);
  endtask

  task automatic t_xmode;
    run(3'd0, 3'd4, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 1, 32'hF, 32'h0);
    check("R10 z not set", 32'h1);
    run(3'd0, 3'd4, 32'h1, 32'h1, 32'h2, 0, 1, 32'hF, 32'h14);
    check("R10 z cleared", 32'h0);
  endtask

  task automatic t_badsize;
    run(3'd0, 3'd3, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 32'hF, 32'h11F);
    check("R11 bad size", 32'h100);
  endtask

  task automatic t_live;
    run(3'd7, 3'd4, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 1, 32'hF, 32'h1234);
    check("R12 live", 32'h1234);
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sizes();
    t_sub();
    t_move();
    t_mul();
    t_mcp();
    t_mask();
    t_xmode();
    t_badsize();
    t_live();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule